// File: doc/BRIEF.md
# Matrix Color Space Converter

This block recolours a video stream one pixel at a time. Each incoming pixel carries three 8-bit channels. Every output channel is a weighted sum of the three input channels plus a constant offset, so a single programmable 3x3 gain matrix with three offsets covers channel reordering, grey conversion, luma/chroma transforms and level shifts. No result depends on neighbouring pixels or lines.

Pixels enter and leave on a valid/ready stream at one pixel per clock. A start-of-frame flag and an end-of-line flag travel alongside each pixel. Coefficients are written through a plain write strobe with an address into a shadow bank. The working bank takes the shadow values only when a start-of-frame pixel is accepted, so a frame is never converted with a mix of two coefficient sets. Results are rounded to the nearest code and clamped to 0..255. A three-register pipeline stalls as one unit under backpressure.

Top module: `csc_affine_top`

## Requirements
- R1: After reset, m_valid is low, s_ready is high, and the working bank holds unit gains on the diagonal with zero offsets, so a pixel leaves unchanged.
- R2: Output channel k equals gk1*in1 + gk2*in2 + gk3*in3 + offset_k. Channel 1 sits in bits [7:0], channel 2 in bits [15:8] and channel 3 in bits [23:16], on both input and output.
- R3: Gains are 18-bit two's complement with 14 fractional bits (16384 is 1.0). This covers at least -2..+2. Offsets are 24-bit two's complement in output codes with 14 fractional bits. Write addresses 0..8 hold the gains row by row (0..2 feed output 1, 3..5 output 2, 6..8 output 3). Addresses 9, 10 and 11 hold the offsets of outputs 1, 2 and 3. A gain write takes data bits [17:0].
- R4: Each result is rounded to the nearest integer code, and an exact half rounds upward.
- R5: A rounded result below 0 leaves as 0, and one above 255 leaves as 255.
- R6: With m_ready held high, a pixel accepted in cycle c appears on the output in cycle c+3.
- R7: While m_valid is high and m_ready is low, the output data and flags hold and s_ready is low. No pixel is lost, repeated or reordered.
- R8: The start-of-frame and end-of-line flags leave in the same beat as the pixel they entered with.
- R9: A coefficient write changes nothing until a pixel with s_user high is accepted. That pixel and every later one use the written values.
- R10: Writes to addresses 12..15 change no coefficient.
- R11: Gains of 1.0 at addresses 2, 4 and 6, all others zero and zero offsets, exchange channels 1 and 3 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient address |
| cfg_wdata | input | 24 | Coefficient value |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted when high with s_valid |
| s_data | input | 24 | Input pixel, three 8-bit channels |
| s_user | input | 1 | Input start-of-frame flag |
| s_last | input | 1 | Input end-of-line flag |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 24 | Converted pixel |
| m_user | output | 1 | Output start-of-frame flag |
| m_last | output | 1 | Output end-of-line flag |

## Verification
A bad stall path shows up within one stalled beat. The output byte changes while m_ready is low, or the sequence numbers in a burst skip or repeat. A wrong bank swap shows up on the very first pixel after a start-of-frame: it either still carries the old conversion or picks up a new one too early, mid-frame. Rounding or clamping faults show up only on the specific codes that fall on a half step or past a range limit, so those codes are driven on purpose and the result is checked three cycles later.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int CH_W   = 8;
  localparam int NCH    = 3;
  localparam int PIX_W  = CH_W * NCH;
  localparam int KW     = 18;
  localparam int OW     = 24;
  localparam int FRAC   = 14;
  localparam int NG     = NCH * NCH;
  localparam int NCOEF  = NG + NCH;
  localparam int AW     = $clog2(NCOEF);
  localparam int PROD_W = CH_W + 1 + KW;
  localparam int ACC_W  = PROD_W + 3;
  localparam int PIPE_D = 3;

  typedef logic signed [KW-1:0]     gain_t;
  typedef logic signed [OW-1:0]     bias_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;

  typedef struct packed {
    logic user;
    logic last;
  } side_t;

  // unit gain on the diagonal, zero elsewhere
  function automatic gain_t gain_init(input int idx);
    return ((idx / NCH) == (idx % NCH)) ? gain_t'(1 <<< FRAC) : gain_t'(0);
  endfunction

  // unsigned channel code times signed gain
  function automatic prod_t scale_chan(input logic [CH_W-1:0] px, input gain_t k);
    prod_t a;
    prod_t b;
    a = prod_t'($signed({1'b0, px}));
    b = prod_t'(k);
    return a * b;
  endfunction

  // round half up, then clamp into one channel code
  function automatic logic [CH_W-1:0] round_clamp(input acc_t acc);
    acc_t t;
    t = (acc + acc_t'(1 <<< (FRAC - 1))) >>> FRAC;
    if (t < 0)
      return '0;
    else if (t > acc_t'((1 << CH_W) - 1))
      return '1;
    else
      return t[CH_W-1:0];
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [OW-1:0]        wr_data,
  input  logic                 swap,
  output gain_t [NG-1:0]       gain_o,
  output bias_t [NCH-1:0]      bias_o
);
  gain_t [NG-1:0]  gain_sh;
  bias_t [NCH-1:0] bias_sh;
  gain_t [NG-1:0]  gain_act;
  bias_t [NCH-1:0] bias_act;

  // shadow bank: written at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) gain_sh[g] <= gain_init(g);
      for (int b = 0; b < NCH; b++) bias_sh[b] <= '0;
    end else if (wr_en) begin
      for (int g = 0; g < NG; g++)
        if (wr_addr == AW'(g)) gain_sh[g] <= wr_data[KW-1:0];
      for (int b = 0; b < NCH; b++)
        if (wr_addr == AW'(NG + b)) bias_sh[b] <= wr_data;
    end
  end

  // working bank: copied only at an accepted start-of-frame pixel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < NG; g++) gain_act[g] <= gain_init(g);
      for (int b = 0; b < NCH; b++) bias_act[b] <= '0;
    end else if (swap) begin
      gain_act <= gain_sh;
      bias_act <= bias_sh;
    end
  end

  assign gain_o = gain_act;
  assign bias_o = bias_act;

  p_swap_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (gain_o == $past(gain_sh)) && (bias_o == $past(bias_sh)));

  p_hold_midframe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(gain_o) && $stable(bias_o));

  p_ignore_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= AW'(NCOEF))) |=> $stable(gain_sh) && $stable(bias_sh));
endmodule

// File: rtl/csc_chan_mac.sv
module csc_chan_mac
  import csc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [PIX_W-1:0]     px_i,
  input  gain_t [NCH-1:0]      gain_row,
  input  bias_t                bias,
  output logic [CH_W-1:0]      px_o
);
  localparam acc_t HALF_CODE = acc_t'(1 <<< (FRAC - 1));
  localparam acc_t SAT_HI_TH = acc_t'((((1 << CH_W) - 1) <<< FRAC) - (1 <<< (FRAC - 1)));

  prod_t prod_q [NCH];
  acc_t  bias_q;
  acc_t  sum;

  // stage 1: three products and the offset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) prod_q[c] <= '0;
      bias_q <= '0;
    end else if (en) begin
      for (int c = 0; c < NCH; c++)
        prod_q[c] <= scale_chan(px_i[c*CH_W +: CH_W], gain_row[c]);
      bias_q <= acc_t'(bias);
    end
  end

  always_comb begin
    sum = bias_q;
    for (int c = 0; c < NCH; c++) sum = sum + acc_t'(prod_q[c]);
  end

  // stage 2: round and clamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      px_o <= '0;
    else if (en)
      px_o <= round_clamp(sum);
  end

  p_clamp_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (sum >= SAT_HI_TH)) |=> (px_o == '1));

  p_clamp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (sum < -HALF_CODE)) |=> (px_o == '0));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(px_o));
endmodule

// File: rtl/csc_affine_top.sv
module csc_affine_top
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [OW-1:0]     cfg_wdata,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  input  logic              s_user,
  input  logic              s_last,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PIX_W-1:0]  m_data,
  output logic              m_user,
  output logic              m_last
);
  logic             advance;
  logic             in_fire;
  logic             sof_take;
  logic             vld_q  [PIPE_D];
  side_t            side_q [PIPE_D];
  logic [PIX_W-1:0] pix0_q;
  gain_t [NG-1:0]   gain_act;
  bias_t [NCH-1:0]  bias_act;
  logic [CH_W-1:0]  out_ch [NCH];

  // whole pipeline moves as one unit
  assign advance  = !vld_q[PIPE_D-1] || m_ready;
  assign s_ready  = advance;
  assign in_fire  = s_valid && advance;
  assign sof_take = in_fire && s_user;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0]  <= 1'b0;
      side_q[0] <= '0;
      pix0_q    <= '0;
    end else if (advance) begin
      vld_q[0]  <= s_valid;
      side_q[0] <= '{user: s_user, last: s_last};
      pix0_q    <= s_data;
    end
  end

  for (genvar s = 1; s < PIPE_D; s++) begin : g_side
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s]  <= 1'b0;
        side_q[s] <= '0;
      end else if (advance) begin
        vld_q[s]  <= vld_q[s-1];
        side_q[s] <= side_q[s-1];
      end
    end
  end

  csc_coef_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .swap    (sof_take),
    .gain_o  (gain_act),
    .bias_o  (bias_act)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    csc_chan_mac u_mac (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (advance),
      .px_i     (pix0_q),
      .gain_row (gain_act[k*NCH +: NCH]),
      .bias     (bias_act[k]),
      .px_o     (out_ch[k])
    );
  end

  always_comb begin
    for (int k = 0; k < NCH; k++) m_data[k*CH_W +: CH_W] = out_ch[k];
  end

  assign m_valid = vld_q[PIPE_D-1];
  assign m_user  = side_q[PIPE_D-1].user;
  assign m_last  = side_q[PIPE_D-1].last;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !m_valid);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_fire, 3) && $past(m_ready, 2) && $past(m_ready, 1)) |-> m_valid);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_user) && $stable(m_last));

  p_in_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);
endmodule

// File: tb/tb_csc_affine_top.sv
module tb_csc_affine_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [23:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_data = '0;
  logic        s_user = 1'b0;
  logic        s_last = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [23:0] m_data;
  logic        m_user;
  logic        m_last;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  csc_affine_top dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_user(s_user), .s_last(s_last),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_user(m_user), .m_last(m_last)
  );

  typedef struct packed {
    logic [1:0]  set;
    logic [23:0] pix;
    logic [23:0] exp;
    logic [23:0] tag;
  } vec_t;

  // set 0 unit, 1 channel exchange, 2 grey 1/4 1/2 1/4, 3 gain 2 / 200-x / x/2
  localparam vec_t VECS [13] = '{
    '{2'd0, 24'h123456, 24'h123456, "R1 "},
    '{2'd0, 24'hFF00A5, 24'hFF00A5, "R2 "},
    '{2'd0, 24'h000000, 24'h000000, "R1 "},
    '{2'd1, 24'h123456, 24'h563412, "R11"},
    '{2'd1, 24'hFF0001, 24'h0100FF, "R11"},
    '{2'd2, 24'hC08040, 24'h808080, "R2 "},
    '{2'd2, 24'hFFFFFF, 24'hFFFFFF, "R3 "},
    '{2'd2, 24'h000001, 24'h000000, "R4 "},
    '{2'd2, 24'h000003, 24'h010101, "R4 "},
    '{2'd2, 24'h000002, 24'h010101, "R4 "},
    '{2'd3, 24'h070A50, 24'h04BEA0, "R4 "},
    '{2'd3, 24'hFFFF90, 24'h8000FF, "R5 "},
    '{2'd3, 24'h000000, 24'h00C800, "R3 "}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // coefficient words per R3 address map
  function automatic logic [23:0] cfg_word(input int s, input int a);
    case (s)
      0: return (a == 0 || a == 4 || a == 8) ? 24'd16384 : 24'd0;
      1: return (a == 2 || a == 4 || a == 6) ? 24'd16384 : 24'd0;
      2: return (a < 9) ? ((a % 3 == 1) ? 24'd8192 : 24'd4096) : 24'd0;
      default: begin
        if (a == 0)  return 24'd32768;
        if (a == 4)  return 24'hFFC000;
        if (a == 8)  return 24'd8192;
        if (a == 10) return 24'd3276800;
        return 24'd0;
      end
    endcase
  endfunction

  task automatic wr(input int a, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_set(input int s);
    for (int a = 0; a < 12; a++) wr(a, cfg_word(s, a));
  endtask

  task automatic send1(input logic [23:0] pix, input logic u, input logic l,
                       output logic [23:0] d, output logic ou, output logic ol, output int lat);
    @(negedge clk);
    m_ready = 1'b1; s_valid = 1'b1; s_data = pix; s_user = u; s_last = l;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_user = 1'b0; s_last = 1'b0;
    lat = 1;
    while (!m_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    d = m_data; ou = m_user; ol = m_last;
  endtask

  function automatic logic [23:0] burst_pix(input int i);
    return {8'(i * 3), 8'(i * 5 + 1), 8'(i * 7 + 2)};
  endfunction

  function automatic logic [23:0] xchg(input logic [23:0] p);
    return {p[7:0], p[15:8], p[23:16]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [23:0] d;
    logic ou, ol;
    int lat;
    int cur;
    logic first;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 m_valid after reset", 32'(m_valid), 32'd0);
    chk("R1 s_ready after reset", 32'(s_ready), 32'd1);

    // table walk
    cur = 0;
    first = 1'b0;
    for (int i = 0; i < 13; i++) begin
      if (int'(VECS[i].set) != cur) begin
        cur = int'(VECS[i].set);
        program_set(cur);
        first = 1'b1;
      end
      send1(VECS[i].pix, first, 1'(i % 2), d, ou, ol, lat);
      chk($sformatf("%s vec %0d data", VECS[i].tag, i), 32'(d), 32'(VECS[i].exp));
      chk($sformatf("R8 vec %0d flags", i), {30'd0, ou, ol}, {30'd0, first, 1'(i % 2)});
      chk($sformatf("R6 vec %0d latency", i), 32'(lat), 32'd3);
      first = 1'b0;
    end

    // R9: writes wait for the next start-of-frame
    program_set(1);
    send1(24'h123456, 1'b0, 1'b0, d, ou, ol, lat);
    chk("R9 old set kept mid-frame", 32'(d), 32'h0994AC);
    send1(24'h123456, 1'b1, 1'b0, d, ou, ol, lat);
    chk("R9 new set at frame start", 32'(d), 32'h563412);

    // R10: unmapped addresses have no effect
    for (int a = 12; a < 16; a++) wr(a, 24'hFFFFFF);
    send1(24'h123456, 1'b1, 1'b0, d, ou, ol, lat);
    chk("R10 unmapped writes ignored", 32'(d), 32'h563412);
    send1(24'hA0B0C0, 1'b0, 1'b0, d, ou, ol, lat);
    chk("R10 unmapped writes ignored 2", 32'(d), 32'hC0B0A0);

    // R7: streaming burst with periodic stalls
    begin : burst
      localparam int NB = 20;
      int sent = 0;
      int got = 0;
      int cyc = 0;
      int unstable = 0;
      logic holding = 1'b0;
      logic [23:0] held = '0;
      logic last_seen = 1'b0;
      while (got < NB && cyc < 2000) begin
        @(negedge clk);
        m_ready = ((cyc % 3) != 1);
        s_valid = (sent < NB);
        s_data  = burst_pix(sent);
        s_user  = 1'b0;
        s_last  = (sent == NB - 1);
        #1;
        if (holding && (m_data !== held)) unstable++;
        if (m_valid && m_ready) begin
          chk($sformatf("R7 burst beat %0d", got), 32'(m_data), 32'(xchg(burst_pix(got))));
          if (got == NB - 1) last_seen = m_last;
          got++;
          holding = 1'b0;
        end else if (m_valid) begin
          held = m_data;
          holding = 1'b1;
        end
        if (s_valid && s_ready) sent++;
        cyc++;
      end
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0; m_ready = 1'b1;
      chk("R7 burst beat count", 32'(got), 32'(NB));
      chk("R7 data held under stall", 32'(unstable), 32'd0);
      chk("R8 end-of-line on final beat", 32'(last_seen), 32'd1);
    end

    repeat (4) @(negedge clk);
    chk("R7 no extra beat", 32'(m_valid), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule